// File: doc/BRIEF.md
# Shadow-Buffered General-Purpose Event Timer

This block is a general-purpose timer for a motor-control event manager. It holds a free-running counter, a working period value and a working compare value. The period and compare values each sit behind a shadow copy. Software writes only the shadow, and the timer moves the value into the working register at a safe point in the count. The counter runs in one of four modes: hold, continuous up, continuous up/down (triangle), or up/down steered by an external direction pin. It counts either on every system clock or on the rising edges of an external clock input.

While the counter steps, four sticky event flags record overflow, underflow, compare match and period match. Each flag has its own mask bit, and the masked flags combine into one interrupt request. A one-clock start-of-conversion pulse follows the event picked by a control field. A compare output gives a PWM level, and a direction output shows the current counting direction.

The CPU side is a single write port with a 3-bit address. Address 0 is control, 1 the period shadow, 2 the compare shadow, 3 the counter, 4 the flag clear and 5 the mask. The working period and compare values are visible on ports.

Top module: `evt_gp_timer`

## Requirements
- R1: On the first cycle after rst_i falls, the counter, prd_o, cmp_o and flags_o are all zero, irq_o and soc_o are low, and dir_o is high.
- R2: When a write to address 0 sets control bits [1:0] to 2'b10 (continuous up) and the internal clock is selected, the counter steps once per clock from 0 up to the working period P and then returns to 0, so one cycle takes P+1 clocks. dir_o stays high.
- R3: With control bits [1:0] = 2'b01 (up/down), the counter climbs to P and falls back to 0, giving a full cycle of 2·P clocks. dir_o goes low on the step away from P and high again on the step away from 0.
- R4: With control bits [1:0] = 2'b11 (directional), the counter steps up while its direction latch is high, wrapping from P to 0. It steps down while the latch is low, wrapping from 0 to P. The latch is high after reset and copies the synchronized dir_pin_i only on a wrapping step, so a pin change in mid-cycle leaves the ongoing sequence alone. dir_o shows the latch.
- R5: With control bits [1:0] = 2'b00 the counter holds its value. A write to address 3 loads the counter in any mode.
- R6: A write to address 1 lands in the period shadow. prd_o copies the shadow only on a clock edge at which the counter is zero.
- R7: A write to address 2 lands in the compare shadow, and control bits [3:2] decide when cmp_o copies it. 2'b00 copies on an edge with the counter at zero. 2'b01 copies on an edge with the counter at zero or equal to prd_o. 2'b10 copies on the write edge itself. 2'b11 never copies.
- R8: Suppose a counting step leaves the counter at 0xFFFF, at 0x0000, at cmp_o or at prd_o. Then flags_o bit 0 (overflow), bit 1 (underflow), bit 2 (compare) or bit 3 (period) sets on the next edge. Counter writes and held values raise no flag.
- R9: Flags stay set until a write to address 4 clears those whose data bit is one. A flag whose event lands on the same edge as the clear stays set.
- R10: irq_o is high exactly when a set flag has its bit set in the mask register, which is written at address 5 from data bits [3:0].
- R11: Control bits [5:4] pick the conversion-start source: 2'b00 none, 2'b01 underflow, 2'b10 period, 2'b11 compare. soc_o is high for one clock, on the same edge that records the chosen event.
- R12: With control bit 6 set, the counter advances once for each rising edge of clk_ext_i after a two-flop synchronizer, and stays put otherwise.
- R13: cmp_out_o is high whenever the counter is greater than or equal to cmp_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | W | Register write data |
| clk_ext_i | input | 1 | External count clock |
| dir_pin_i | input | 1 | Direction request for directional mode, high = up |
| cnt_o | output | W | Counter value |
| prd_o | output | W | Working period value |
| cmp_o | output | W | Working compare value |
| dir_o | output | 1 | Current counting direction, high = up |
| cmp_out_o | output | 1 | Compare output level |
| flags_o | output | 4 | Sticky flags: overflow, underflow, compare, period (bits 0..3) |
| irq_o | output | 1 | Masked interrupt request |
| soc_o | output | 1 | Start-of-conversion pulse |

## Verification
The assertions assume that software writes a shadow register only on edges where that shadow is not being copied into its working register. They also assume that clk_ext_i toggles no faster than a quarter of the system clock rate, so that every edge survives the synchronizer. The stimulus writes the period and compare shadows either while the counter is clearly away from zero or before counting starts. It drives the external clock with three-cycle high and low phases, and it changes the direction pin only when there is time for two sync stages before the next wrap.

// File: rtl/evt_gp_timer_pkg.sv
package evt_gp_timer_pkg;

  typedef enum logic [1:0] {
    MODE_STOP = 2'b00,
    MODE_UPDN = 2'b01,
    MODE_UP   = 2'b10,
    MODE_DIRN = 2'b11
  } cnt_mode_e;

  typedef enum logic [1:0] {
    RLD_ZERO     = 2'b00,
    RLD_ZERO_PRD = 2'b01,
    RLD_NOW      = 2'b10,
    RLD_NONE     = 2'b11
  } cmp_rld_e;

  typedef enum logic [1:0] {
    SOC_OFF = 2'b00,
    SOC_UNF = 2'b01,
    SOC_PRD = 2'b10,
    SOC_CMP = 2'b11
  } soc_src_e;

  // control word, bit 6 down to bit 0
  typedef struct packed {
    logic      ext_clk;
    soc_src_e  soc_src;
    cmp_rld_e  rld;
    cnt_mode_e mode;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned NFLAG  = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_PRD  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CLR  = 3'd4;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd5;

  localparam int unsigned FL_OVF = 0;
  localparam int unsigned FL_UNF = 1;
  localparam int unsigned FL_CMP = 2;
  localparam int unsigned FL_PRD = 3;

endpackage

// File: rtl/evt_tick_gen.sv
module evt_tick_gen #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic sel_ext_i,
  input  logic ext_i,
  output logic tick_o
);
  localparam int unsigned SH_W = STAGES + 1;

  logic [SH_W-1:0] sh_q;
  logic            ext_rise;

  always_ff @(posedge clk_i) begin
    if (rst_i) sh_q <= '0;
    else       sh_q <= {sh_q[SH_W-2:0], ext_i};
  end

  // synchronized level is sh_q[STAGES-1]; sh_q[STAGES] is its delayed copy
  assign ext_rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign tick_o   = sel_ext_i ? ext_rise : 1'b1;

endmodule

// File: rtl/evt_shadow_regs.sv
module evt_shadow_regs
  import evt_gp_timer_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         wr_prd_i,
  input  logic         wr_cmp_i,
  input  logic [W-1:0] wdata_i,
  input  cmp_rld_e     rld_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] prd_o,
  output logic [W-1:0] cmp_o
);
  logic [W-1:0] prd_sh_q, cmp_sh_q, prd_q, cmp_q;
  logic         at_zero, at_prd;

  assign at_zero = (cnt_i == '0);
  assign at_prd  = (cnt_i == prd_q);

  function automatic logic cmp_load(input cmp_rld_e r, input logic z, input logic p);
    case (r)
      RLD_ZERO:     cmp_load = z;
      RLD_ZERO_PRD: cmp_load = z | p;
      RLD_NOW:      cmp_load = 1'b1;
      default:      cmp_load = 1'b0;
    endcase
  endfunction

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prd_sh_q <= '0;
      cmp_sh_q <= '0;
      prd_q    <= '0;
      cmp_q    <= '0;
    end else begin
      if (wr_prd_i) prd_sh_q <= wdata_i;
      if (wr_cmp_i) cmp_sh_q <= wdata_i;
      if (at_zero)  prd_q    <= prd_sh_q;
      if (rld_i == RLD_NOW && wr_cmp_i) cmp_q <= wdata_i;
      else if (cmp_load(rld_i, at_zero, at_prd)) cmp_q <= cmp_sh_q;
    end
  end

  assign prd_o = prd_q;
  assign cmp_o = cmp_q;

endmodule

// File: rtl/evt_count_core.sv
module evt_count_core
  import evt_gp_timer_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter int unsigned PIN_SYNC = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  cnt_mode_e    mode_i,
  input  logic         tick_i,
  input  logic [W-1:0] prd_i,
  input  logic         dir_pin_i,
  input  logic         cnt_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic         up_o,
  output logic         fresh_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] ONE = W'(1);

  typedef struct packed {
    logic [W-1:0] cnt;
    logic         up;
    logic         wrap;
  } step_t;

  logic [W-1:0]        cnt_q;
  logic                up_q, fresh_q;
  logic [PIN_SYNC-1:0] pin_sh_q;
  logic                pin_s;
  logic                step_en;
  step_t               nx;

  assign pin_s = pin_sh_q[PIN_SYNC-1];

  function automatic step_t next_step(input cnt_mode_e m, input logic [W-1:0] c,
                                      input logic [W-1:0] p, input logic up,
                                      input logic pin);
    step_t s;
    s.cnt  = c;
    s.up   = up;
    s.wrap = 1'b0;
    case (m)
      MODE_UP: begin
        s.up = 1'b1;
        if (c >= p) begin s.cnt = '0; s.wrap = 1'b1; end
        else s.cnt = c + ONE;
      end
      MODE_UPDN: begin
        if (p == '0) begin
          s.cnt = '0;
        end else if (up) begin
          if (c >= p) begin s.up = 1'b0; s.cnt = c - ONE; s.wrap = 1'b1; end
          else s.cnt = c + ONE;
        end else begin
          if (c == '0) begin s.up = 1'b1; s.cnt = c + ONE; s.wrap = 1'b1; end
          else s.cnt = c - ONE;
        end
      end
      MODE_DIRN: begin
        if (up) begin
          if (c >= p) begin s.cnt = '0; s.wrap = 1'b1; s.up = pin; end
          else s.cnt = c + ONE;
        end else begin
          if (c == '0) begin s.cnt = p; s.wrap = 1'b1; s.up = pin; end
          else s.cnt = c - ONE;
        end
      end
      default: ;
    endcase
    return s;
  endfunction

  assign nx      = next_step(mode_i, cnt_q, prd_i, up_q, pin_s);
  assign step_en = tick_i && (mode_i != MODE_STOP) && !cnt_wr_i;

  generate
    if (PIN_SYNC == 1) begin : g_sync1
      always_ff @(posedge clk_i) begin
        if (rst_i) pin_sh_q <= '0;
        else       pin_sh_q <= dir_pin_i;
      end
    end else begin : g_syncn
      always_ff @(posedge clk_i) begin
        if (rst_i) pin_sh_q <= '0;
        else       pin_sh_q <= {pin_sh_q[PIN_SYNC-2:0], dir_pin_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q   <= '0;
      up_q    <= 1'b1;
      fresh_q <= 1'b0;
    end else begin
      fresh_q <= step_en;
      if (cnt_wr_i) begin
        cnt_q <= wdata_i;
      end else if (step_en) begin
        cnt_q <= nx.cnt;
        up_q  <= nx.up;
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign up_o    = up_q;
  assign fresh_o = fresh_q;
  assign wrap_o  = step_en && nx.wrap;

endmodule

// File: rtl/evt_flag_unit.sv
module evt_flag_unit
  import evt_gp_timer_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [W-1:0]     cnt_i,
  input  logic             fresh_i,
  input  logic [W-1:0]     prd_i,
  input  logic [W-1:0]     cmp_i,
  input  soc_src_e         soc_src_i,
  input  logic             clr_wr_i,
  input  logic [NFLAG-1:0] clr_bits_i,
  input  logic [NFLAG-1:0] mask_i,
  output logic [NFLAG-1:0] ev_o,
  output logic [NFLAG-1:0] flags_o,
  output logic             irq_o,
  output logic             soc_o
);
  logic [NFLAG-1:0] flags_q, clr_mask;
  logic             soc_q, soc_pick;

  assign ev_o[FL_OVF] = fresh_i && (cnt_i == '1);
  assign ev_o[FL_UNF] = fresh_i && (cnt_i == '0);
  assign ev_o[FL_CMP] = fresh_i && (cnt_i == cmp_i);
  assign ev_o[FL_PRD] = fresh_i && (cnt_i == prd_i);

  assign clr_mask = clr_wr_i ? clr_bits_i : '0;

  always_comb begin
    case (soc_src_i)
      SOC_UNF: soc_pick = ev_o[FL_UNF];
      SOC_PRD: soc_pick = ev_o[FL_PRD];
      SOC_CMP: soc_pick = ev_o[FL_CMP];
      default: soc_pick = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      flags_q <= '0;
      soc_q   <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~clr_mask) | ev_o;
      soc_q   <= soc_pick;
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & mask_i);
  assign soc_o   = soc_q;

endmodule

// File: rtl/evt_gp_timer.sv
module evt_gp_timer
  import evt_gp_timer_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter int unsigned EXT_SYNC = 2,
  parameter int unsigned PIN_SYNC = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic              clk_ext_i,
  input  logic              dir_pin_i,
  output logic [W-1:0]      cnt_o,
  output logic [W-1:0]      prd_o,
  output logic [W-1:0]      cmp_o,
  output logic              dir_o,
  output logic              cmp_out_o,
  output logic [NFLAG-1:0]  flags_o,
  output logic              irq_o,
  output logic              soc_o
);
  ctrl_t            ctrl_q;
  logic [NFLAG-1:0] mask_q;
  cnt_mode_e        mode_w;
  logic             ctrl_wr_w, prd_wr_w, cmp_wr_w, cnt_wr_w, clr_wr_w, mask_wr_w;
  logic             tick_w, fresh_w, wrap_w;
  logic [NFLAG-1:0] ev_w;

  assign ctrl_wr_w = wr_en_i && (wr_addr_i == A_CTRL);
  assign prd_wr_w  = wr_en_i && (wr_addr_i == A_PRD);
  assign cmp_wr_w  = wr_en_i && (wr_addr_i == A_CMP);
  assign cnt_wr_w  = wr_en_i && (wr_addr_i == A_CNT);
  assign clr_wr_w  = wr_en_i && (wr_addr_i == A_CLR);
  assign mask_wr_w = wr_en_i && (wr_addr_i == A_MASK);
  assign mode_w    = ctrl_q.mode;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else begin
      if (ctrl_wr_w) ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
      if (mask_wr_w) mask_q <= wr_data_i[NFLAG-1:0];
    end
  end

  evt_tick_gen #(.STAGES(EXT_SYNC)) tick_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .sel_ext_i (ctrl_q.ext_clk),
    .ext_i     (clk_ext_i),
    .tick_o    (tick_w)
  );

  evt_shadow_regs #(.W(W)) shadow_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .wr_prd_i (prd_wr_w),
    .wr_cmp_i (cmp_wr_w),
    .wdata_i  (wr_data_i),
    .rld_i    (ctrl_q.rld),
    .cnt_i    (cnt_o),
    .prd_o    (prd_o),
    .cmp_o    (cmp_o)
  );

  evt_count_core #(.W(W), .PIN_SYNC(PIN_SYNC)) core_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .mode_i    (mode_w),
    .tick_i    (tick_w),
    .prd_i     (prd_o),
    .dir_pin_i (dir_pin_i),
    .cnt_wr_i  (cnt_wr_w),
    .wdata_i   (wr_data_i),
    .cnt_o     (cnt_o),
    .up_o      (dir_o),
    .fresh_o   (fresh_w),
    .wrap_o    (wrap_w)
  );

  evt_flag_unit #(.W(W)) flag_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .cnt_i      (cnt_o),
    .fresh_i    (fresh_w),
    .prd_i      (prd_o),
    .cmp_i      (cmp_o),
    .soc_src_i  (ctrl_q.soc_src),
    .clr_wr_i   (clr_wr_w),
    .clr_bits_i (wr_data_i[NFLAG-1:0]),
    .mask_i     (mask_q),
    .ev_o       (ev_w),
    .flags_o    (flags_o),
    .irq_o      (irq_o),
    .soc_o      (soc_o)
  );

  assign cmp_out_o = (cnt_o >= cmp_o);

endmodule

// File: rtl/evt_gp_timer_chk.sv
module evt_gp_timer_chk
  import evt_gp_timer_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic             clk,
  input logic             rst,
  input cnt_mode_e        mode,
  input logic             cnt_wr,
  input logic             clr_wr,
  input logic             wrap,
  input logic [W-1:0]     cnt,
  input logic [W-1:0]     prd,
  input logic [NFLAG-1:0] flags,
  input logic             dir,
  input logic             soc
);

  // R2: up mode keeps the counter inside the period
  a_r2_up_within_period: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_UP && !cnt_wr && cnt <= prd) |=> (cnt <= $past(prd)));

  // R4: directional latch only moves on a wrapping step
  a_r4_dir_moves_at_wrap: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_DIRN && !wrap) |=> $stable(dir));

  // R5: hold mode freezes the counter unless software writes it
  a_r5_stop_holds: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_STOP && !cnt_wr) |=> $stable(cnt));

  // R6: working period changes only after an edge seen with the counter at zero
  a_r6_period_loads_at_zero: assert property (@(posedge clk) disable iff (rst)
    !$stable(prd) |-> ($past(cnt) == '0));

  // R9: without a clear write no flag falls
  a_r9_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_wr |=> ((flags & $past(flags)) == $past(flags)));

  // R11: a conversion-start pulse always comes with a recorded flag
  a_r11_soc_with_flag: assert property (@(posedge clk) disable iff (rst)
    soc |-> (flags != '0));

endmodule

bind evt_gp_timer evt_gp_timer_chk #(.W(W)) chk_i (
  .clk    (clk_i),
  .rst    (rst_i),
  .mode   (mode_w),
  .cnt_wr (cnt_wr_w),
  .clr_wr (clr_wr_w),
  .wrap   (wrap_w),
  .cnt    (cnt_o),
  .prd    (prd_o),
  .flags  (flags_o),
  .dir    (dir_o),
  .soc    (soc_o)
);

// File: tb/evt_gp_timer_tb_top.sv
module evt_gp_timer_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         clk_ext = 1'b0;
  logic         dir_pin = 1'b1;
  logic [W-1:0] cnt, prd, cmp;
  logic         dir, cmp_out, irq, soc;
  logic [3:0]   flags;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  evt_gp_timer #(.W(W)) dut_i (
    .clk_i     (clk),
    .rst_i     (rst),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .clk_ext_i (clk_ext),
    .dir_pin_i (dir_pin),
    .cnt_o     (cnt),
    .prd_o     (prd),
    .cmp_o     (cmp),
    .dir_o     (dir),
    .cmp_out_o (cmp_out),
    .flags_o   (flags),
    .irq_o     (irq),
    .soc_o     (soc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0; clk_ext = 1'b0; dir_pin = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  function automatic int up_val(int k, int p);
    return k % (p + 1);
  endfunction

  function automatic int tri_val(int k, int p);
    int pos = k % (2 * p);
    return (pos <= p) ? pos : 2 * p - pos;
  endfunction

  function automatic bit tri_dir(int k, int p);
    int pos = k % (2 * p);
    return (pos >= 1) && (pos <= p);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 cnt", cnt, 0);
    chk("R1 prd", prd, 0);
    chk("R1 cmp", cmp, 0);
    chk("R1 flags", flags, 0);
    chk("R1 irq", irq, 0);
    chk("R1 soc", soc, 0);
    chk("R1 dir", dir, 1);

    // R2 continuous up sweep over small periods
    for (int p = 0; p <= 5; p++) begin
      do_reset();
      wr(3'd1, W'(p));
      wr(3'd0, 16'h0002);
      for (int k = 1; k <= 2 * (p + 1) + 2; k++) begin
        step();
        chk("R2 up count", cnt, up_val(k, p));
        chk("R2 up dir", dir, 1);
      end
    end

    // R3 up/down sweep
    for (int p = 1; p <= 5; p++) begin
      do_reset();
      wr(3'd1, W'(p));
      wr(3'd0, 16'h0001);
      for (int k = 1; k <= 4 * p + 2; k++) begin
        step();
        chk("R3 updown count", cnt, tri_val(k, p));
        chk("R3 updown dir", dir, tri_dir(k, p));
      end
    end

    // R11 / R8 / R13 : up mode P=4, compare 2, each start source
    for (int src = 1; src <= 3; src++) begin
      do_reset();
      wr(3'd1, 16'd4);
      wr(3'd2, 16'd2);
      wr(3'd0, W'((src << 4) | 2));
      for (int k = 1; k <= 12; k++) begin
        int  pc;
        bit  ev;
        step();
        pc = up_val(k - 1, 4);
        ev = (src == 1) ? (pc == 0) : (src == 2) ? (pc == 4) : (pc == 2);
        chk("R11 soc pulse", soc, (k >= 2) && ev);
        chk("R13 compare output", cmp_out, up_val(k, 4) >= 2);
        if (src == 1) begin
          if (k == 2) chk("R8 no flag yet", flags, 4'b0000);
          if (k == 3) chk("R8 compare flag", flags, 4'b0100);
          if (k == 5) chk("R8 period flag", flags, 4'b1100);
          if (k == 6) chk("R8 underflow flag", flags, 4'b1110);
        end
      end
    end
    // stop and exercise mask and clear
    wr(3'd0, 16'h0030);
    step(); step();
    chk("R8 flags after stop", flags, 4'b1110);
    chk("R10 irq masked off", irq, 0);
    wr(3'd5, 16'h0004);
    chk("R10 irq compare mask", irq, 1);
    wr(3'd4, 16'h0004);
    chk("R9 clear compare", flags, 4'b1010);
    chk("R10 irq after clear", irq, 0);
    wr(3'd4, 16'h0001);
    chk("R9 clear of idle bit", flags, 4'b1010);
    wr(3'd5, 16'h0008);
    chk("R10 irq period mask", irq, 1);

    // R9 set beats clear: P=0 up mode makes events every clock
    do_reset();
    wr(3'd0, 16'h0002);
    step(); step(); step();
    wr(3'd4, 16'h000F);
    chk("R9 set wins over clear", flags, 4'b1110);

    // R8 overflow at all ones
    do_reset();
    wr(3'd1, 16'hFFFF);
    wr(3'd3, 16'hFFFD);
    wr(3'd0, 16'h0002);
    step(); chk("R8 ovf count", cnt, 16'hFFFE);
    step(); chk("R8 no ovf yet", flags, 4'b0000);
    step(); chk("R8 ovf and period flags", flags, 4'b1001);
    chk("R8 wrap to zero", cnt, 0);

    // R6 period shadow reload only at zero
    do_reset();
    wr(3'd1, 16'd4);
    wr(3'd0, 16'h0002);
    step(); step();
    wr(3'd1, 16'd2);
    chk("R6 count at write", cnt, 3);
    begin
      int ec[5] = '{4, 0, 1, 2, 0};
      int ep[5] = '{4, 4, 2, 2, 2};
      for (int i = 0; i < 5; i++) begin
        step();
        chk("R6 count", cnt, ec[i]);
        chk("R6 working period", prd, ep[i]);
      end
    end

    // R7 compare reload rules, in hold mode; R5 and R13 alongside
    do_reset();
    wr(3'd1, 16'd4);
    wr(3'd2, 16'd7);
    step();
    chk("R7 zero reload", cmp, 7);
    wr(3'd3, 16'd5);
    wr(3'd2, 16'd9);
    step(); step();
    chk("R7 no reload away from zero", cmp, 7);
    chk("R5 hold count", cnt, 5);
    wr(3'd3, 16'd0);
    step();
    chk("R7 reload on zero", cmp, 9);
    wr(3'd0, 16'h0004);
    wr(3'd3, 16'd3);
    wr(3'd2, 16'd11);
    step(); step();
    chk("R7 zero-or-period waits", cmp, 9);
    wr(3'd3, 16'd4);
    step();
    chk("R7 reload at period", cmp, 11);
    wr(3'd0, 16'h0008);
    wr(3'd2, 16'd13);
    chk("R7 immediate reload", cmp, 13);
    wr(3'd0, 16'h000C);
    wr(3'd2, 16'd15);
    wr(3'd3, 16'd0);
    step(); step();
    chk("R7 reserved never reloads", cmp, 13);
    chk("R13 below compare", cmp_out, 0);
    wr(3'd3, 16'd20);
    step(); step(); step();
    chk("R5 hold after write", cnt, 20);
    chk("R13 above compare", cmp_out, 1);

    // R4 directional mode, P=3
    do_reset();
    wr(3'd1, 16'd3);
    wr(3'd0, 16'h0003);
    begin
      int ec[11] = '{1, 2, 3, 0, 3, 2, 1, 0, 3, 0, 1};
      int ed[11] = '{1, 1, 1, 0, 0, 0, 0, 0, 1, 1, 1};
      for (int k = 1; k <= 11; k++) begin
        step();
        chk("R4 directional count", cnt, ec[k-1]);
        chk("R4 direction", dir, ed[k-1]);
        if (k == 1) dir_pin = 1'b0;
        if (k == 6) dir_pin = 1'b1;
      end
    end

    // R12 external clock
    do_reset();
    wr(3'd1, 16'd100);
    wr(3'd0, 16'h0042);
    repeat (6) step();
    chk("R12 idle external clock", cnt, 0);
    for (int n = 0; n < 5; n++) begin
      clk_ext = 1'b1; repeat (3) step();
      clk_ext = 1'b0; repeat (3) step();
    end
    repeat (4) step();
    chk("R12 external count", cnt, 5);
    repeat (4) step();
    chk("R12 holds without edges", cnt, 5);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule